// File: doc/BRIEF.md
# Shared Ready-Strobe and Serial-Data Pin Controller

This block drives one output pin that serves two purposes in turn. A free-running sequencer splits every conversion period of 384 system clocks into five fixed phases. At the start of the period the filter's 24-bit result is captured into an output word register. The pin then gives a short low strobe to announce the new word. For most of the period after that, the pin carries the word serially, MSB first, advanced by an external serial clock. A final high guard stretch leads into the next period.

The serial clock idles low and is asynchronous to the system clock. It is brought into the system-clock domain through a two-flop synchronizer, and each detected falling edge moves the pin to the next bit. The reader samples on the rising edge. If the filter reports that its output has not settled yet, the strobe for that period is withheld and the pin stays high. This tells the reader that the word is not worth fetching.

The sequencer has five named states, taken in a fixed ring:
- WRITE (6 clocks): captures the word, and the pin is high.
- STROBE_LO (6 clocks): the pin is low, unless the strobe is suppressed.
- STROBE_HI (6 clocks): the pin is high.
- SHIFT (342 clocks): the pin carries the data bits.
- GUARD (24 clocks): the pin is high.

Each state passes to the next when its timer reaches its length, and GUARD wraps back to WRITE.

Top module: `ddo_pin_ctrl`

## Requirements
- R1: Counting system clock edges from reset release as position p (modulo 384), the phases are: write at p 0 to 5, strobe-low at p 6 to 11, strobe-high at p 12 to 17, shift at p 18 to 359 and guard at p 360 to 383, and the pattern repeats every 384 clocks.
- R2: The pin is high throughout the write phase.
- R3: The result word and the settled flag are captured on the clock edge that ends the write phase (leaving p 5). With settled captured as 1, the pin is low throughout the strobe-low phase. Later changes of the result input do not affect the word being shifted.
- R4: With settled captured as 0, the pin stays high throughout the strobe-low phase.
- R5: The pin is high throughout the strobe-high phase and throughout the guard phase.
- R6: At the first shift position the pin shows bit 23 (the MSB) of the captured word.
- R7: After k synchronized falling edges of the serial clock within the shift phase (k below 24), the pin shows bit 23-k of the word. Each change appears at most 3 system-clock edges after the falling edge.
- R8: When fewer than 24 falling edges arrive in the shift phase (including none), the pin holds the last bit presented until the shift phase ends.
- R9: After 24 or more falling edges in the shift phase, the pin is low until the shift phase ends.
- R10: Falling edges outside the shift phase have no effect. The bit pointer is reset at the start of the write phase and at the start of the strobe-high phase, so every shift phase starts at the MSB of the new word.
- R11: While reset is asserted the pin is high. After release the sequencer starts at the beginning of the write phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | External serial clock, asynchronous, idle low |
| result_i | input | 24 | Result word from the filter |
| settled_i | input | 1 | Filter output has settled; 0 suppresses the strobe |
| dout_rdy_o | output | 1 | Shared ready-strobe / serial data pin |

## Verification
The hardest situation to reach from the ports is the pointer reset when serial clock edges arrive outside the shift phase, or are left over from a previous read. A reader that stays in step would never produce it. The stimulus fires serial clock pulses on purpose inside the write, strobe-low and guard windows. It then checks that the next shift phase still opens on the MSB. Over-long reads of 30 edges and partial reads are also driven, and the pin is sampled late in the shift phase to check the held level. A reset applied in the middle of a shift shows that the sequence restarts at the write phase.

// File: rtl/ddo_pkg.sv
package ddo_pkg;

    typedef enum logic [2:0] {
        ST_WRITE     = 3'd0,
        ST_STROBE_LO = 3'd1,
        ST_STROBE_HI = 3'd2,
        ST_SHIFT     = 3'd3,
        ST_GUARD     = 3'd4
    } seq_state_e;

endpackage

// File: rtl/sclk_edge_sync.sv
module sclk_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    output logic fall_o
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-2:0], sclk_i};
            prev_q  <= chain_q[SYNC_STAGES-1];
        end
    end

    // a high-to-low step seen on the synchronized level
    assign fall_o = prev_q & ~chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/cycle_sequencer.sv
module cycle_sequencer
    import ddo_pkg::*;
#(
    parameter int CYCLE_LEN = 384,
    parameter int WRITE_LEN = 6,
    parameter int LOW_LEN   = 6,
    parameter int HIGH_LEN  = 6,
    parameter int GUARD_LEN = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    output seq_state_e state_o,
    output logic       load_o,
    output logic       ptr_clr_o
);

    localparam int SHIFT_LEN = CYCLE_LEN - WRITE_LEN - LOW_LEN - HIGH_LEN - GUARD_LEN;
    localparam int TMR_W     = $clog2(CYCLE_LEN);

    seq_state_e       state_q, state_nx;
    logic [TMR_W-1:0] tmr_q, tmr_nx;
    logic [TMR_W-1:0] last_tick;
    logic             at_last;

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WRITE;
            tmr_q   <= '0;
        end else begin
            state_q <= state_nx;
            tmr_q   <= tmr_nx;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_WRITE:     last_tick = TMR_W'(WRITE_LEN - 1);
            ST_STROBE_LO: last_tick = TMR_W'(LOW_LEN - 1);
            ST_STROBE_HI: last_tick = TMR_W'(HIGH_LEN - 1);
            ST_SHIFT:     last_tick = TMR_W'(SHIFT_LEN - 1);
            ST_GUARD:     last_tick = TMR_W'(GUARD_LEN - 1);
            default:      last_tick = '0;
        endcase
    end

    assign at_last = (tmr_q == last_tick);

    // next-state process
    always_comb begin
        state_nx = state_q;
        tmr_nx   = tmr_q + 1'b1;
        if (at_last) begin
            tmr_nx = '0;
            unique case (state_q)
                ST_WRITE:     state_nx = ST_STROBE_LO;
                ST_STROBE_LO: state_nx = ST_STROBE_HI;
                ST_STROBE_HI: state_nx = ST_SHIFT;
                ST_SHIFT:     state_nx = ST_GUARD;
                ST_GUARD:     state_nx = ST_WRITE;
                default:      state_nx = ST_WRITE;
            endcase
        end
    end

    // output process
    always_comb begin
        load_o    = 1'b0;
        ptr_clr_o = 1'b0;
        unique case (state_q)
            ST_WRITE: begin
                load_o    = at_last;
                ptr_clr_o = (tmr_q == '0);
            end
            ST_STROBE_HI: ptr_clr_o = (tmr_q == '0);
            default: begin
                load_o    = 1'b0;
                ptr_clr_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/out_shift_reg.sv
module out_shift_reg #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              settled_i,
    input  logic              ptr_clr_i,
    input  logic              adv_i,
    output logic [WORD_W-1:0] word_o,
    output logic [WORD_W-1:0] sh_o,
    output logic              strobe_en_o
);

    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] sh_q;
    logic              strobe_q;

    // output word register, written once per conversion period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            strobe_q <= 1'b0;
        end else if (load_i) begin
            word_q   <= word_i;
            strobe_q <= settled_i;
        end
    end

    // shifter: rewinding to the MSB equals clearing the bit pointer;
    // zeros fill from below so that an over-read reads low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (ptr_clr_i) begin
            sh_q <= word_q;
        end else if (adv_i) begin
            sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    assign word_o      = word_q;
    assign sh_o        = sh_q;
    assign strobe_en_o = strobe_q;

endmodule

// File: rtl/ddo_pin_ctrl.sv
module ddo_pin_ctrl
    import ddo_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int CYCLE_LEN   = 384,
    parameter int WRITE_LEN   = 6,
    parameter int LOW_LEN     = 6,
    parameter int HIGH_LEN    = 6,
    parameter int GUARD_LEN   = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic [WORD_W-1:0] result_i,
    input  logic              settled_i,
    output logic              dout_rdy_o
);

    seq_state_e        state;
    logic              load;
    logic              ptr_clr;
    logic              sclk_fall;
    logic              adv;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] sh_q;
    logic              strobe_en;

    sclk_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_i (sclk_i),
        .fall_o (sclk_fall)
    );

    cycle_sequencer #(
        .CYCLE_LEN (CYCLE_LEN),
        .WRITE_LEN (WRITE_LEN),
        .LOW_LEN   (LOW_LEN),
        .HIGH_LEN  (HIGH_LEN),
        .GUARD_LEN (GUARD_LEN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_o   (state),
        .load_o    (load),
        .ptr_clr_o (ptr_clr)
    );

    // serial edges count only inside the shift phase
    assign adv = sclk_fall & (state == ST_SHIFT);

    out_shift_reg #(
        .WORD_W (WORD_W)
    ) u_oreg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .word_i      (result_i),
        .settled_i   (settled_i),
        .ptr_clr_i   (ptr_clr),
        .adv_i       (adv),
        .word_o      (word_q),
        .sh_o        (sh_q),
        .strobe_en_o (strobe_en)
    );

    // pin multiplexing
    always_comb begin
        unique case (state)
            ST_WRITE:     dout_rdy_o = 1'b1;
            ST_STROBE_LO: dout_rdy_o = ~strobe_en;
            ST_STROBE_HI: dout_rdy_o = 1'b1;
            ST_SHIFT:     dout_rdy_o = sh_q[WORD_W-1];
            ST_GUARD:     dout_rdy_o = 1'b1;
            default:      dout_rdy_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/ddo_pin_ctrl_chk.sv
module ddo_pin_ctrl_chk
    import ddo_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input seq_state_e        state,
    input logic [WORD_W-1:0] sh_q,
    input logic [WORD_W-1:0] word_q,
    input logic              sclk_fall,
    input logic              pin
);

    a_r1_write_then_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |=> (state == ST_WRITE || state == ST_STROBE_LO));

    a_r1_guard_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GUARD) |=> (state == ST_GUARD || state == ST_WRITE));

    a_r5_guard_pin_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GUARD) |-> pin);

    a_r6_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_SHIFT) |-> (sh_q == word_q));

    a_r8_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !sclk_fall) |=> $stable(sh_q));

    a_r9_overread_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && sh_q == '0) |=> (sh_q == '0));

    a_r10_guard_ignores_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GUARD) |=> $stable(sh_q));

endmodule

bind ddo_pin_ctrl ddo_pin_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .sh_q      (sh_q),
    .word_q    (word_q),
    .sclk_fall (sclk_fall),
    .pin       (dout_rdy_o)
);

// File: tb/ddo_pin_ctrl_bench.sv
`timescale 1ns/1ps
module ddo_pin_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sclk;
    logic [23:0] result;
    logic        settled;
    logic        pin;
    int          pos;
    int          n_cmp  = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    ddo_pin_ctrl u_ddo_pin_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (sclk),
        .result_i   (result),
        .settled_i  (settled),
        .dout_rdy_o (pin)
    );

    // position within the conversion period, counted from reset release
    always @(posedge clk) begin
        if (!rst_n) pos <= 0;
        else        pos <= (pos == 383) ? 0 : pos + 1;
    end

    // word, settled, number of serial falling edges
    localparam logic [30:0] VEC [6] = '{
        {24'hA5C3F0, 1'b1, 6'd0},
        {24'h123456, 1'b1, 6'd24},
        {24'h800001, 1'b1, 6'd7},
        {24'h7FFFFE, 1'b1, 6'd30},
        {24'h5A5A5A, 1'b0, 6'd3},
        {24'hFFFFFF, 1'b1, 6'd1}
    };

    task automatic chk(input logic got, input logic exp, input string req);
        n_cmp++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s at pos %0d: got %b expected %b", req, pos, got, exp);
        end
    endtask

    task automatic wait_pos(input int k);
        while (pos != k) @(negedge clk);
    endtask

    task automatic pulse();
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic bit_after(input logic [23:0] w, input int k);
        return (k < 24) ? w[23-k] : 1'b0;
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n   = 1'b0;
        sclk    = 1'b0;
        result  = '0;
        settled = 1'b0;
        repeat (5) @(negedge clk);
        chk(pin, 1'b1, "R11 pin high in reset");
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < 6; i++) begin
            logic [23:0] w;
            logic        s;
            int          n;
            w = VEC[i][30:7];
            s = VEC[i][6];
            n = int'(VEC[i][5:0]);
            wait_pos(0);
            result  = w;
            settled = s;
            wait_pos(2);
            chk(pin, 1'b1, "R2 write phase high");
            wait_pos(5);
            chk(pin, 1'b1, "R1 last write clock");
            wait_pos(6);
            if (s) chk(pin, 1'b0, "R3 strobe low starts");
            else   chk(pin, 1'b1, "R4 strobe suppressed");
            wait_pos(11);
            chk(pin, !s, s ? "R1 strobe low end" : "R4 strobe suppressed end");
            wait_pos(12);
            chk(pin, 1'b1, "R5 strobe-high phase");
            wait_pos(18);
            chk(pin, w[23], "R6 msb first");
            wait_pos(19);
            for (int k = 1; k <= n; k++) begin
                pulse();
                chk(pin, bit_after(w, k), "R7 bit advance");
            end
            wait_pos(359);
            chk(pin, bit_after(w, n), (n < 24) ? "R8 held bit" : "R9 low after over-read");
            wait_pos(360);
            chk(pin, 1'b1, "R1 guard starts");
            wait_pos(370);
            chk(pin, 1'b1, "R5 guard high");
        end

        // edges outside the shift phase, late input change
        wait_pos(0);
        result  = 24'h3CC3A5;
        settled = 1'b1;
        wait_pos(1);
        pulse();                       // during write / strobe-low
        result = 24'hC33C5A;           // after capture
        wait_pos(18);
        chk(pin, 1'b0, "R10 msb after stray edges");
        wait_pos(19);
        pulse();
        chk(pin, 1'b0, "R3 captured word bit22");
        pulse();
        chk(pin, 1'b1, "R3 captured word bit21");
        wait_pos(361);
        pulse();                       // during guard
        wait_pos(375);
        chk(pin, 1'b1, "R10 guard edge ignored");

        // next period starts from the MSB despite earlier reads
        wait_pos(0);
        result = 24'h8F0F0F;
        wait_pos(18);
        chk(pin, 1'b1, "R10 pointer rewound to msb");
        wait_pos(19);
        pulse();
        chk(pin, 1'b0, "R7 second bit");

        // reset in the middle of the shift phase
        wait_pos(200);
        rst_n = 1'b0;
        @(negedge clk);
        chk(pin, 1'b1, "R11 pin high on reset");
        repeat (3) @(negedge clk);
        rst_n   = 1'b1;
        result  = 24'h400000;
        settled = 1'b1;
        wait_pos(3);
        chk(pin, 1'b1, "R11 restart in write phase");
        wait_pos(7);
        chk(pin, 1'b0, "R11 strobe after restart");
        wait_pos(18);
        chk(pin, 1'b0, "R6 msb after restart");
        wait_pos(19);
        pulse();
        chk(pin, 1'b1, "R7 bit22 after restart");

        finish_run();
    end

endmodule